// File: doc/BRIEF.md
# Dual-Table Waveform Display Sequencer

This block keeps two tables of Y samples, table A and table B, in internal memory. Each table holds `N_PTS` entries, and an entry's index stands for its X position. Table B's positions sit half a step to the right of table A's, so the two tables together give points at twice the density. During acquisition the block takes one digital Y word per cycle, together with an index and a flag that picks the table. Writes into table A can be frozen by a save control. Writes into table B are never frozen.

A display pulse starts one pass through the tables. The pass emits one point per clock, and each point carries a display X, a display Y, a trace identifier and a first-point strobe. The view is chosen from four options:

- table A only;
- table B only;
- both tables, which gives either one interlaced trace or two separate traces;
- the saturated, mid-scale-offset difference of B minus A.

The block also raises a pause request whenever the point it is emitting falls on the index that was acquired last. The drawing side uses this request to brighten an update marker.

Top module: `wave_display_seq`

## Requirements
- R1: After reset, `pt_valid`, `pt_trace_start` and `marker_pause` are low, and they stay low until a display pass is started.
- R2: A cycle with `acq_valid` high and `acq_x < N_PTS` writes `acq_y` into table B at index `acq_x` when `acq_sel`=1. When `acq_sel`=0 and `save_a`=0, it writes `acq_y` into table A at that index. When `acq_x >= N_PTS`, the sample changes nothing.
- R3: While `save_a`=1, samples with `acq_sel`=0 leave table A unchanged, and table B is still written.
- R4: View code 0 (table A) emits `N_PTS` points. Point i has X = 2i, Y = A[i] and trace 0.
- R5: View code 1 (table B) emits `N_PTS` points. Point i has X = 2i, Y = B[i] and trace 0.
- R6: View code 2 with `save_a`=0 at the start pulse emits 2·`N_PTS` points on trace 0. Point k has X = k. Its Y is A[k/2] when k is even and B[k/2] when k is odd.
- R7: View code 2 with `save_a`=1 at the start pulse emits two traces:
  - first, A[i] for each i on trace 0, with X = 2i;
  - then, B[i] for each i on trace 1, with X = 2i.
- R8: View code 3 emits `N_PTS` points. Point i has X = 2i and Y = 2^(YW-1) + B[i] − A[i], clamped to the range 0..2^YW−1.
- R9: `pt_trace_start` is high on the first point of each trace, and on no other point.
- R10: `marker_pause` is high exactly when `pt_valid` is high and `pt_x` >> 1 equals the index of the most recent in-range acquisition sample, from either table. That index is 0 after reset.
- R11: Points come on consecutive cycles. The view code and `save_a` are taken at the start pulse, and later changes to them have no effect on the pass. A start pulse that arrives during a pass is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_valid | input | 1 | Acquisition sample present |
| acq_sel | input | 1 | Table of the sample: 0 = A, 1 = B |
| acq_x | input | clog2(N_PTS) | Table index of the sample |
| acq_y | input | YW | Sample value |
| save_a | input | 1 | Freeze table A and select two-trace dual view |
| disp_mode | input | 2 | View: 0 A, 1 B, 2 both, 3 B minus A |
| disp_start | input | 1 | Start pulse for one display pass |
| pt_valid | output | 1 | Display point present |
| pt_x | output | XW | Display X position |
| pt_y | output | YW | Display Y value |
| pt_trace | output | 1 | Trace identifier of the point |
| pt_trace_start | output | 1 | First point of a trace |
| marker_pause | output | 1 | Pause request for the update marker |

## Verification
The bench builds the block with `N_PTS`=6, `YW`=8 and `XW`=5. With six entries the index field is three bits wide, so indices 6 and 7 are real out-of-range writes that the bench can issue. A display X field wider than the index plus one bit checks that the upper X bits are zero-filled. Every view and both save settings fit into short passes. The four difference cases cover the clamp at zero, the clamp at full scale, equal entries giving mid-scale, and an ordinary negative difference. A start pulse is also sent in the middle of a pass, together with changes to the view code.

// File: rtl/wds_pkg.sv
package wds_pkg;
  typedef enum logic [1:0] {
    VIEW_A    = 2'd0,
    VIEW_B    = 2'd1,
    VIEW_AB   = 2'd2,
    VIEW_DIFF = 2'd3
  } view_t;
endpackage

// File: rtl/wds_tables.sv
module wds_tables #(
  parameter int N_PTS = 500,
  parameter int YW    = 8,
  parameter int IW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_valid,
  input  logic          acq_sel,
  input  logic [IW-1:0] acq_x,
  input  logic [YW-1:0] acq_y,
  input  logic          save_a,
  input  logic [IW-1:0] rd_idx,
  output logic [YW-1:0] rd_a,
  output logic [YW-1:0] rd_b,
  output logic          acq_hit
);
  logic [YW-1:0] mem_a [N_PTS];
  logic [YW-1:0] mem_b [N_PTS];
  logic wr_a, wr_b;

  assign acq_hit = acq_valid && ({1'b0, acq_x} < (IW+1)'(N_PTS));
  assign wr_a    = acq_hit && !acq_sel && !save_a;
  assign wr_b    = acq_hit && acq_sel;

  always_ff @(posedge clk) begin
    if (wr_a) mem_a[acq_x] <= acq_y;
    if (wr_b) mem_b[acq_x] <= acq_y;
    rd_a <= mem_a[rd_idx];
    rd_b <= mem_b[rd_idx];
  end

  // R3: a frozen table A keeps its entry across an attempted write
  assert_save_holds_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_valid && !acq_sel && save_a && ({1'b0, acq_x} < (IW+1)'(N_PTS)))
      |=> mem_a[$past(acq_x)] == $past(mem_a[acq_x]));
endmodule

// File: rtl/wds_scan.sv
module wds_scan
  import wds_pkg::*;
#(
  parameter int N_PTS = 500,
  parameter int XW    = 10,
  parameter int IW    = 9,
  parameter int CW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_start,
  input  view_t         disp_mode,
  input  logic          save_a,
  output logic          s_valid,
  output logic [IW-1:0] s_idx,
  output logic          s_tsel,
  output logic          s_trace,
  output logic          s_start,
  output logic [XW-1:0] s_x,
  output logic          s_ilv,
  output logic          s_diff
);
  localparam logic [CW-1:0] NC    = CW'(N_PTS);
  localparam logic [CW-1:0] LAST1 = CW'(N_PTS - 1);
  localparam logic [CW-1:0] LAST2 = CW'(2 * N_PTS - 1);

  logic          busy, save_q;
  view_t         mode_q;
  logic [CW-1:0] cnt;
  logic          dual, second, last;

  always_comb begin
    s_ilv  = (mode_q == VIEW_AB) && !save_q;
    dual   = (mode_q == VIEW_AB) && save_q;
    second = dual && (cnt >= NC);
    if (s_ilv)       s_idx = cnt[CW-1:1];
    else if (second) s_idx = IW'(cnt - NC);
    else             s_idx = cnt[IW-1:0];
    s_tsel  = s_ilv ? cnt[0] : ((mode_q == VIEW_B) || second);
    s_trace = second;
    s_x     = s_ilv ? XW'(cnt) : XW'({s_idx, 1'b0});
    s_valid = busy;
    s_start = busy && (s_ilv ? (cnt == '0) : (s_idx == '0));
    s_diff  = (mode_q == VIEW_DIFF);
    last    = (mode_q == VIEW_AB) ? (cnt == LAST2) : (cnt == LAST1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      mode_q <= VIEW_A;
      save_q <= 1'b0;
    end else if (!busy) begin
      if (disp_start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        mode_q <= disp_mode;
        save_q <= save_a;
      end
    end else if (last) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R11: a pass advances one point per cycle until its last point
  assert_pass_advances_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && cnt == $past(cnt) + 1'b1));
  // R11: view and save settings stay fixed during a pass
  assert_view_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (mode_q == $past(mode_q) && save_q == $past(save_q)));
endmodule

// File: rtl/wave_display_seq.sv
module wave_display_seq
  import wds_pkg::*;
#(
  parameter int N_PTS = 500,
  parameter int YW    = 8,
  parameter int XW    = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acq_valid,
  input  logic                       acq_sel,
  input  logic [$clog2(N_PTS)-1:0]   acq_x,
  input  logic [YW-1:0]              acq_y,
  input  logic                       save_a,
  input  logic [1:0]                 disp_mode,
  input  logic                       disp_start,
  output logic                       pt_valid,
  output logic [XW-1:0]              pt_x,
  output logic [YW-1:0]              pt_y,
  output logic                       pt_trace,
  output logic                       pt_trace_start,
  output logic                       marker_pause
);
  localparam int IW = $clog2(N_PTS);
  localparam int CW = IW + 1;
  localparam logic signed [YW+1:0] MID  = (YW+2)'(1 << (YW - 1));
  localparam logic signed [YW+1:0] TOPV = (YW+2)'((1 << YW) - 1);

  // Offset difference B - A around mid-scale, clamped to the Y range
  function automatic logic [YW-1:0] sub_offset(input logic [YW-1:0] b, input logic [YW-1:0] a);
    logic signed [YW+1:0] t;
    t = $signed({2'b00, b}) - $signed({2'b00, a}) + MID;
    if (t < 0)         return '0;
    else if (t > TOPV) return '1;
    else               return t[YW-1:0];
  endfunction

  logic          s_valid, s_tsel, s_trace, s_start, s_ilv, s_diff;
  logic [IW-1:0] s_idx;
  logic [XW-1:0] s_x;
  logic [YW-1:0] rd_a, rd_b;
  logic          acq_hit;
  logic          p_tsel, p_diff, p_ilv;
  logic [IW-1:0] last_acq;

  wds_scan #(.N_PTS(N_PTS), .XW(XW), .IW(IW), .CW(CW)) u_scan (
    .clk(clk), .rst_n(rst_n), .disp_start(disp_start),
    .disp_mode(view_t'(disp_mode)), .save_a(save_a),
    .s_valid(s_valid), .s_idx(s_idx), .s_tsel(s_tsel), .s_trace(s_trace),
    .s_start(s_start), .s_x(s_x), .s_ilv(s_ilv), .s_diff(s_diff)
  );

  wds_tables #(.N_PTS(N_PTS), .YW(YW), .IW(IW)) u_tables (
    .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_sel(acq_sel),
    .acq_x(acq_x), .acq_y(acq_y), .save_a(save_a), .rd_idx(s_idx),
    .rd_a(rd_a), .rd_b(rd_b), .acq_hit(acq_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pt_valid       <= 1'b0;
      pt_x           <= '0;
      pt_trace       <= 1'b0;
      pt_trace_start <= 1'b0;
      p_tsel         <= 1'b0;
      p_diff         <= 1'b0;
      p_ilv          <= 1'b0;
      last_acq       <= '0;
    end else begin
      pt_valid       <= s_valid;
      pt_x           <= s_x;
      pt_trace       <= s_trace;
      pt_trace_start <= s_start;
      p_tsel         <= s_tsel;
      p_diff         <= s_diff;
      p_ilv          <= s_ilv;
      if (acq_hit) last_acq <= acq_x;
    end
  end

  assign pt_y         = p_diff ? sub_offset(rd_b, rd_a) : (p_tsel ? rd_b : rd_a);
  assign marker_pause = pt_valid && (pt_x[XW-1:1] == (XW-1)'(last_acq));

  // R6: interlaced points step by one X position
  assert_interlace_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_valid && p_ilv && !pt_trace_start) |-> (pt_x == $past(pt_x) + 1'b1));
  // R9: the second trace begins with a start strobe
  assert_second_trace_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pt_trace) |-> pt_trace_start);
  // R9: a start strobe sits at table index 0
  assert_start_at_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pt_trace_start |-> (pt_valid && pt_x[XW-1:1] == '0));
endmodule

// File: tb/wave_display_seq_bench.sv
module wave_display_seq_bench;
  localparam int N  = 6;
  localparam int YW = 8;
  localparam int XW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_valid = 1'b0, acq_sel = 1'b0, save_a = 1'b0, disp_start = 1'b0;
  logic [2:0] acq_x = '0;
  logic [YW-1:0] acq_y = '0;
  logic [1:0] disp_mode = '0;
  logic pt_valid, pt_trace, pt_trace_start, marker_pause;
  logic [XW-1:0] pt_x;
  logic [YW-1:0] pt_y;

  always #2 clk = ~clk;

  wave_display_seq #(.N_PTS(N), .YW(YW), .XW(XW)) u_wave_display_seq (
    .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_sel(acq_sel),
    .acq_x(acq_x), .acq_y(acq_y), .save_a(save_a), .disp_mode(disp_mode),
    .disp_start(disp_start), .pt_valid(pt_valid), .pt_x(pt_x), .pt_y(pt_y),
    .pt_trace(pt_trace), .pt_trace_start(pt_trace_start), .marker_pause(marker_pause)
  );

  int checks = 0, errors = 0;
  int ma [N];
  int mb [N];
  int last_idx = 0;
  int ncap = 0;
  int cx [16], cy [16], ctr [16], cst [16], cmk [16];

  always @(negedge clk) begin
    if (pt_valid && ncap < 16) begin
      cx[ncap] = pt_x; cy[ncap] = pt_y; ctr[ncap] = pt_trace;
      cst[ncap] = pt_trace_start; cmk[ncap] = marker_pause;
      ncap++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic acq(input bit sel, input int idx, input int y);
    @(negedge clk);
    acq_valid = 1'b1; acq_sel = sel; acq_x = 3'(idx); acq_y = 8'(y);
    @(negedge clk);
    acq_valid = 1'b0;
    if (idx < N) begin
      last_idx = idx;
      if (sel) mb[idx] = y;
      else if (!save_a) ma[idx] = y;
    end
  endtask

  task automatic run_frame(input int mode, input bit sv, input bit again);
    ncap = 0;
    @(negedge clk);
    save_a = sv; disp_mode = 2'(mode); disp_start = 1'b1;
    @(negedge clk);
    disp_start = 1'b0; disp_mode = 2'(mode ^ 1); save_a = ~sv;
    if (again) begin
      @(negedge clk); @(negedge clk);
      disp_start = 1'b1;
      @(negedge clk);
      disp_start = 1'b0;
    end
    repeat (2 * N + 6) @(negedge clk);
    save_a = sv;
  endtask

  task automatic check_frame(input string req, input int mode, input bit sv);
    int total;
    total = (mode == 2) ? 2 * N : N;
    chk(req, "point count", ncap, total);
    for (int k = 0; k < total && k < ncap; k++) begin
      int i, ex, ey, etr, est, d;
      etr = 0;
      if (mode == 2 && !sv) begin
        i = k / 2; ex = k; ey = (k % 2 == 1) ? mb[i] : ma[i];
      end else if (mode == 2) begin
        i = (k < N) ? k : k - N; ex = 2 * i;
        ey = (k < N) ? ma[i] : mb[i]; etr = (k < N) ? 0 : 1;
      end else begin
        i = k; ex = 2 * i;
        if (mode == 0) ey = ma[i];
        else if (mode == 1) ey = mb[i];
        else begin
          d = 128 + mb[i] - ma[i];
          ey = (d < 0) ? 0 : ((d > 255) ? 255 : d);
        end
      end
      est = (mode == 2 && !sv) ? (k == 0) : (i == 0);
      chk(req, $sformatf("x[%0d]", k), cx[k], ex);
      chk(req, $sformatf("y[%0d]", k), cy[k], ey);
      chk(req, $sformatf("trace[%0d]", k), ctr[k], etr);
      chk("R9", $sformatf("start[%0d]", k), cst[k], est);
      chk("R10", $sformatf("marker[%0d]", k), cmk[k], int'((ex / 2) == last_idx));
    end
  endtask

  task automatic t_reset();
    int seen = 0;
    repeat (5) begin
      @(negedge clk);
      if (pt_valid || pt_trace_start || marker_pause) seen++;
    end
    chk("R1", "outputs active after reset", seen, 0);
  endtask

  task automatic t_load();
    for (int i = 0; i < N; i++) begin
      acq(1'b0, i, 10 + 7 * i);
      acq(1'b1, i, 90 + 11 * i);
    end
    run_frame(0, 1'b0, 1'b0);
    check_frame("R4", 0, 1'b0);
    run_frame(1, 1'b0, 1'b0);
    check_frame("R5", 1, 1'b0);
  endtask

  task automatic t_views();
    run_frame(2, 1'b0, 1'b0);
    check_frame("R6", 2, 1'b0);
    run_frame(2, 1'b1, 1'b0);
    check_frame("R7", 2, 1'b1);
  endtask

  task automatic t_save();
    save_a = 1'b1;
    acq(1'b0, 1, 222);
    acq(1'b1, 1, 33);
    run_frame(0, 1'b1, 1'b0);
    check_frame("R3", 0, 1'b1);
    chk("R3", "frozen A[1]", cy[1], 17);
    run_frame(1, 1'b1, 1'b0);
    check_frame("R3", 1, 1'b1);
    chk("R3", "B[1] still written", cy[1], 33);
    save_a = 1'b0;
  endtask

  task automatic t_diff();
    acq(1'b0, 0, 200); acq(1'b1, 0, 10);
    acq(1'b0, 1, 10);  acq(1'b1, 1, 250);
    acq(1'b0, 2, 77);  acq(1'b1, 2, 77);
    acq(1'b0, 3, 100); acq(1'b1, 3, 50);
    run_frame(3, 1'b0, 1'b0);
    check_frame("R8", 3, 1'b0);
    chk("R8", "clamp low", cy[0], 0);
    chk("R8", "clamp high", cy[1], 255);
    chk("R8", "mid-scale", cy[2], 128);
    chk("R8", "negative diff", cy[3], 78);
  endtask

  task automatic t_marker();
    int marks = 0;
    acq(1'b1, 3, 144);
    acq(1'b1, 7, 5);
    acq(1'b0, 6, 9);
    chk("R2", "out-of-range leaves marker index", last_idx, 3);
    run_frame(2, 1'b0, 1'b0);
    check_frame("R2", 2, 1'b0);
    for (int k = 0; k < ncap; k++) marks += cmk[k];
    chk("R10", "marker point count", marks, 2);
    chk("R10", "marker on x=7", cmk[7], 1);
  endtask

  task automatic t_restart();
    run_frame(0, 1'b0, 1'b1);
    check_frame("R11", 0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin ma[i] = 0; mb[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_views();
    t_save();
    t_diff();
    t_marker();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule